// File: doc/BRIEF.md
# Disk-to-Memory Burst DMA Engine

This block moves a stream of bytes from a byte-wide disk interface into 16-bit system memory without help from the CPU. It packs each pair of incoming bytes into one word and queues the words in a small FIFO. When enough words are queued, it asks for the system bus. Once the bus is granted, it writes one word per cycle to an incrementing destination address. It hands the bus back as soon as the FIFO runs empty. Each word crosses the bus once, going straight from the engine to memory, so the transfer takes half the bus time of a copy where the CPU reads each word and then writes it.

Software writes the destination address and then the byte count. Writing the count starts the transfer, and the engine runs on its own from there. When the last word has been written, a done flag and an interrupt go high. If the bus grant comes too late and the FIFO fills, the engine drops its byte-ready signal, which holds the source back. No byte is ever dropped or overwritten.

Register map, word offsets on `reg_addr`: 0 is the destination address, 1 is the byte count, 2 is status. Reading offset 0 gives the next write address and reading offset 1 gives the bytes still to be accepted. Status bit 0 is done and bit 1 is busy.

Top module: `disk_burst_dma`

## Requirements
- R1: Bytes are packed in arrival order. The first byte of each pair goes to bits 15:8 of the word and the second byte to bits 7:0. Words reach memory in the order they were packed.
- R2: A register write of a nonzero count to offset 1 while the engine is idle starts a transfer. That transfer performs exactly ceil(count/2) bus writes. A count of zero is ignored: busy stays 0 and `in_ready` stays low.
- R3: `bus_req` rises only when the FIFO holds at least WMARK (12) words, or when every byte has been accepted and words remain. Once raised, it stays high until the bus is granted.
- R4: `bus_req` falls in the cycle the FIFO becomes empty, and not before.
- R5: `in_ready` is low whenever the FIFO is full. With a late grant, the source is held off and no byte is lost.
- R6: The first word goes to the destination address with bit 0 cleared. Each following word goes to the previous address plus 2. Reading offset 0 returns the address the next word would use.
- R7: If the count is odd, the final byte is placed in bits 15:8 of the last word and bits 7:0 are zero.
- R8: After the last word has been written and the FIFO is empty, status bit 0 (done) is 1, busy (bit 1) is 0, and `irq` is high.
- R9: Any register write to offset 2 clears done and `irq`.
- R10: `bus_we` is only asserted while `bus_gnt` is high, and each asserted cycle writes one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte source has a byte |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational on reg_addr |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_addr | output | ADDR_W | Byte address of the current word write |
| bus_wdata | output | 16 | Word being written |
| bus_we | output | 1 | Word write strobe, one word per cycle |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench drives transfers of odd and even lengths and with gaps in the byte stream. It also uses a grant held back for 30 cycles, which must make `in_ready` drop. A design that overruns its FIFO would show corrupted or missing words in the bench memory. A design that loses the odd final byte or pads it on the wrong side fails the last-word compare. A bench-side occupancy count is taken at every rise and fall of `bus_req`. It catches an engine that requests the bus early, fails to flush a short tail below the watermark, or drops the bus with words still queued. An unaligned destination, a zero count and the clear of status by a write are also driven and read back through the register port.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OFS_DEST = 2'd0,
    OFS_LEN  = 2'd1,
    OFS_STAT = 2'd2,
    OFS_RSVD = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/dbd_fifo.sv
module dbd_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wdata;
  end

  assign rdata = mem[rd_ptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R10
endmodule

// File: rtl/dbd_packer.sv
module dbd_packer
  import dbd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic              active,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              fifo_full,
  output logic              push,
  output logic [WORD_W-1:0] push_word,
  output logic              all_in,
  output logic [LEN_W-1:0]  bytes_left
);
  logic [LEN_W-1:0]  left_q, left_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic              have_hi_q, have_hi_d;
  logic              take;

  assign in_ready = active && (left_q != '0) && !fifo_full;
  assign take     = in_valid && in_ready;

  always_comb begin
    left_d    = left_q;
    hi_d      = hi_q;
    have_hi_d = have_hi_q;
    push      = 1'b0;
    push_word = '0;
    if (start) begin
      left_d    = len;
      have_hi_d = 1'b0;
    end else if (take) begin
      left_d = left_q - 1'b1;
      if (have_hi_q) begin
        push      = 1'b1;
        push_word = {hi_q, in_data};
        have_hi_d = 1'b0;
      end else if (left_q == LEN_W'(1)) begin
        push      = 1'b1;
        push_word = {in_data, {BYTE_W{1'b0}}};
      end else begin
        hi_d      = in_data;
        have_hi_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q    <= '0;
      hi_q      <= '0;
      have_hi_q <= 1'b0;
    end else begin
      left_q    <= left_d;
      hi_q      <= hi_d;
      have_hi_q <= have_hi_d;
    end
  end

  assign all_in     = (left_q == '0) && !have_hi_q;
  assign bytes_left = left_q;

  AST_PAIR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    have_hi_q |-> left_q != '0); // R1
endmodule

// File: rtl/dbd_busmaster.sv
module dbd_busmaster #(
  parameter int ADDR_W = 24,
  parameter int DEPTH  = 16,
  parameter int WMARK  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dest_load,
  input  logic [ADDR_W-1:0] dest,
  input  logic [CNT_W-1:0]  count,
  input  logic              push,
  input  logic              flush,
  input  logic              gnt,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr
);
  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_next;
  logic              trigger;

  assign we       = req_q && gnt && (count != '0);
  assign cnt_next = count + CNT_W'(push) - CNT_W'(we);
  assign trigger  = (count >= CNT_W'(WMARK)) || (flush && (count != '0));

  always_comb begin
    req_d  = req_q ? (cnt_next != '0) : trigger;
    addr_d = addr_q;
    if (dest_load)  addr_d = {dest[ADDR_W-1:1], 1'b0};
    else if (we)    addr_d = addr_q + ADDR_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
    end
  end

  assign req  = req_q;
  assign addr = addr_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !gnt) |=> req_q); // R3
  AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> count == '0); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !dest_load) |=> addr_q == $past(addr_q) + ADDR_W'(2)); // R6
  AST_WE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (gnt && req_q)); // R10
endmodule

// File: rtl/disk_burst_dma.sv
module disk_burst_dma
  import dbd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int REG_W  = 32,
  parameter int DEPTH  = 16,
  parameter int WMARK  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  output logic              bus_we,
  output logic              irq
);
  logic              busy_q, busy_d, done_q, done_d;
  logic              start, dest_load, stat_wr, finish;
  logic              push, all_in, fifo_full, fifo_empty;
  logic [WORD_W-1:0] push_word;
  logic [CNT_W-1:0]  fifo_count;
  logic [LEN_W-1:0]  bytes_left;
  logic [LEN_W-1:0]  len_field;
  logic              unused_wdata;

  assign len_field    = reg_wdata[LEN_W-1:0];
  assign unused_wdata = ^reg_wdata;
  assign dest_load    = reg_wr && (reg_addr == OFS_DEST) && !busy_q;
  assign start        = reg_wr && (reg_addr == OFS_LEN) && !busy_q && (len_field != '0);
  assign stat_wr      = reg_wr && (reg_addr == OFS_STAT);
  assign finish       = busy_q && all_in && fifo_empty && !bus_req;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    if (start)       busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    if (finish)       done_d = 1'b1;
    else if (stat_wr) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  dbd_packer #(.LEN_W(LEN_W)) u_packer (
    .clk, .rst_n,
    .start      (start),
    .len        (len_field),
    .active     (busy_q),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .fifo_full  (fifo_full),
    .push       (push),
    .push_word  (push_word),
    .all_in     (all_in),
    .bytes_left (bytes_left)
  );

  dbd_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk, .rst_n,
    .push  (push),
    .wdata (push_word),
    .pop   (bus_we),
    .rdata (bus_wdata),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  dbd_busmaster #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .WMARK(WMARK)) u_bus (
    .clk, .rst_n,
    .dest_load (dest_load),
    .dest      (reg_wdata[ADDR_W-1:0]),
    .count     (fifo_count),
    .push      (push),
    .flush     (all_in),
    .gnt       (bus_gnt),
    .req       (bus_req),
    .we        (bus_we),
    .addr      (bus_addr)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_DEST: reg_rdata = REG_W'(bus_addr);
      OFS_LEN:  reg_rdata = REG_W'(bytes_left);
      OFS_STAT: reg_rdata = REG_W'({busy_q, done_q});
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = done_q;

  AST_IRQ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (fifo_empty && !bus_req && all_in)); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !finish) |=> !irq); // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !bus_req); // R2
endmodule

// File: tb/disk_burst_dma_tb.sv
module disk_burst_dma_tb;
  localparam int ADDR_W = 24;
  localparam int REG_W  = 32;
  localparam int WM     = 12;
  // {len[15:0], dest[15:0], grant_delay[15:0], gap[7:0], expect_throttle[7:0]}
  localparam logic [63:0] VEC [5] = '{
    {16'd32, 16'h0010, 16'd0,  8'd0, 8'd0},
    {16'd7,  16'h0080, 16'd2,  8'd1, 8'd0},
    {16'd64, 16'h0100, 16'd30, 8'd0, 8'd1},
    {16'd25, 16'h0041, 16'd5,  8'd2, 8'd0},
    {16'd2,  16'h01FE, 16'd0,  8'd0, 8'd0}
  };

  logic clk, rst_n;
  logic in_valid, in_ready, reg_wr, bus_req, bus_gnt, bus_we, irq;
  logic [7:0] in_data;
  logic [1:0] reg_addr;
  logic [REG_W-1:0] reg_wdata, reg_rdata;
  logic [ADDR_W-1:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] mem [512];
  int checks, errors, cycles;

  disk_burst_dma u_dut (
    .clk, .rst_n, .in_valid, .in_data, .in_ready, .reg_wr, .reg_addr,
    .reg_wdata, .reg_rdata, .bus_req, .bus_gnt, .bus_addr, .bus_wdata,
    .bus_we, .irq
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int i, int v);
    return 8'((i * 7 + v * 29 + 3) & 255);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_vec(int v);
    int len, dest, dly, gap, thr, base, nw;
    int acc, wr, gcnt, tick, t, pushed, bad, err3, err4, err10;
    bit tp, wp, prev_req, thr_seen;
    logic [31:0] rd;
    logic [15:0] expw;
    len  = int'(VEC[v][63:48]);
    dest = int'(VEC[v][47:32]);
    dly  = int'(VEC[v][31:16]);
    gap  = int'(VEC[v][15:8]);
    thr  = int'(VEC[v][7:0]);
    base = dest & ~1;
    nw   = (len + 1) / 2;
    for (int i = 0; i < 512; i++) mem[i] = 16'hDEAD;
    reg_write(2'd0, 32'(dest));
    reg_write(2'd1, 32'(len));
    acc = 0; wr = 0; gcnt = 0; tick = 0; t = 0; pushed = 0;
    err3 = 0; err4 = 0; err10 = 0;
    tp = 0; wp = 0; prev_req = 0; thr_seen = 0;
    while (t < 6000) begin
      @(negedge clk);
      t++;
      if (tp) acc++;
      if (wp) wr++;
      pushed = (acc == len) ? (acc + 1) / 2 : acc / 2;
      if (bus_req && !prev_req && !((pushed - wr) >= WM || acc == len)) err3++;
      if (!bus_req && prev_req && (pushed != wr)) err4++;
      prev_req = bus_req;
      if (bus_req) gcnt++; else gcnt = 0;
      bus_gnt = bus_req && (gcnt > dly);
      tick++;
      in_valid = (acc < len) && ((tick % (gap + 1)) == 0);
      in_data  = pat(acc, v);
      #1;
      tp = in_valid && in_ready;
      if (in_valid && !in_ready) thr_seen = 1;
      wp = 0;
      if (bus_we) begin
        if (!bus_gnt) err10++;
        mem[bus_addr[9:1]] = bus_wdata;
        wp = 1;
      end
      if (irq) break;
    end
    if (wp) wr++;
    in_valid = 1'b0;
    bus_gnt  = 1'b0;
    chk($sformatf("R8 irq raised v%0d", v), 32'(irq), 32'd1);
    chk($sformatf("R2 word writes v%0d", v), 32'(wr), 32'(nw));
    bad = 0;
    for (int k = 0; k < nw; k++) begin
      expw = {pat(2 * k, v), (2 * k + 1 < len) ? pat(2 * k + 1, v) : 8'h00};
      if (mem[((base >> 1) + k) & 511] !== expw) bad++;
    end
    chk($sformatf("R1 packed data mismatches v%0d", v), 32'(bad), 32'd0);
    if (len % 2 == 1)
      chk($sformatf("R7 odd tail word v%0d", v),
          32'(mem[((base >> 1) + nw - 1) & 511]), 32'({pat(len - 1, v), 8'h00}));
    chk($sformatf("R3 early request v%0d", v), 32'(err3), 32'd0);
    chk($sformatf("R4 release not empty v%0d", v), 32'(err4), 32'd0);
    chk($sformatf("R10 write without grant v%0d", v), 32'(err10), 32'd0);
    chk($sformatf("R5 throttle seen v%0d", v), 32'(thr_seen), 32'(thr));
    reg_read(2'd0, rd);
    chk($sformatf("R6 next address v%0d", v), rd, 32'(base + 2 * nw));
    reg_read(2'd2, rd);
    chk($sformatf("R8 status done v%0d", v), rd, 32'd1);
    reg_write(2'd2, 32'd0);
    reg_read(2'd2, rd);
    chk($sformatf("R9 status cleared v%0d", v), rd, 32'd0);
    chk($sformatf("R9 irq cleared v%0d", v), 32'(irq), 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    checks = 0; errors = 0; cycles = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0; bus_gnt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_read(2'd2, rd);
    chk("R8 reset status", rd, 32'd0);
    chk("R3 reset bus_req", 32'(bus_req), 32'd0);
    chk("R5 reset in_ready", 32'(in_ready), 32'd0);
    chk("R8 reset irq", 32'(irq), 32'd0);

    reg_write(2'd1, 32'd0);
    reg_read(2'd2, rd);
    chk("R2 zero count ignored", rd, 32'd0);
    chk("R2 zero count no ready", 32'(in_ready), 32'd0);

    for (int v = 0; v < 5; v++) run_vec(v);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule